// File: doc/BRIEF.md
# Masked Pin Change Interrupt Unit

This unit watches eight general-purpose input pins and raises one shared interrupt request whenever an enabled pin changes its logic level. A level change in either direction counts. Each pin is first brought into the clock domain through a two-stage synchroniser. The synchronised value is then compared with the value recorded one cycle earlier. The pin change events are reduced to a single sticky pending flag.

Three controls decide whether a change leads to a request. An eight-bit mask enables each pin on its own. A group enable bit in a control register must also be set before any change is considered. The request leaves the unit only while the group enable and an external global interrupt enable are both high. The flag clears when the processor acknowledges the vector, or when software writes a one to the flag bit. A change that arrives in the same cycle as a clear still sets the flag.

Software reaches the unit through a plain register port. A write takes effect on the clock edge. Read data is combinational from the address. This port carries no stream data, so it has no valid/ready handshake and applies no back-pressure.

Top module: `pinchg_irq`

## Requirements
- R1: After reset the mask register (address 0), the control register (address 1), the flag register (address 2) and `irq` all read zero.
- R2: A write to address 0 stores all eight mask bits. A write to address 1 stores only bit 5 (the group enable), and the other bits of that register read zero.
- R3: When both the mask bit of a pin and the group enable are set, a level change of that pin, applied just after a rising edge, sets flag bit 5 of address 2 on the third rising edge that follows. Flag bit 5 reads 0 after the first and second of those edges.
- R4: A change on a pin whose mask bit is clear leaves the flag unset. Any pin change while the group enable is clear also leaves the flag unset.
- R5: `irq` is high exactly when the flag, the group enable and `gie` are all high. It follows them in the same cycle.
- R6: A high `vec_ack` clears the flag on the next edge. A write to address 2 with bit 5 set also clears it on the next edge. A write to address 2 with bit 5 clear leaves the flag unchanged.
- R7: If a pin change event and a clear (acknowledge or write-one) fall in the same cycle, the flag is set after that edge.
- R8: The last-value history follows every pin whatever its mask. Setting a mask bit for a pin that changed while it was masked creates no event.
- R9: Both a rising and a falling level change of an enabled pin set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins | input | 8 | Asynchronous pin levels being watched |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | 1 | Processor acknowledge of the pin-change vector |
| reg_addr | input | 2 | Register select: 0 mask, 1 control, 2 flag |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Shared interrupt request |

## Verification
A pin change driven just after an edge reaches the flag on the third rising edge. The edges are the two synchroniser stages and then the flag register. Register writes, acknowledges and write-one clears act on the first edge. `irq` and read data follow the state within the same cycle. The bench drives inputs 2 ns after each rising edge. It updates its behavioural model on the rising edge and compares `irq` and read data at each falling edge, so every result is checked in the cycle the requirements assign to it. Targeted checks sample the flag after the first, second and third edges, and the same-cycle acknowledge is placed in the cycle between the second and third edges.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
  localparam int unsigned NPINS  = 8;
  localparam int unsigned AW     = 2;
  localparam int unsigned FLAG_B = 5;
  localparam int unsigned GRP_B  = 5;

  typedef enum logic [AW-1:0] {
    A_MASK = 2'd0,
    A_CTRL = 2'd1,
    A_FLAG = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/pinchg_detect.sv
module pinchg_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] mask,
  input  logic         grp_en,
  output logic         event_o
);
  logic [W-1:0] last;
  logic [W-1:0] toggled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= '0;
    else        last <= level;
  end

  assign toggled = (level ^ last) & mask;
  assign event_o = grp_en & (|toggled);
endmodule

// File: rtl/pinchg_regs.sv
module pinchg_regs
  import pinchg_pkg::*;
#(
  parameter int unsigned W = NPINS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wdata,
  input  logic          set_evt,
  input  logic          ack,
  output logic [W-1:0]  mask,
  output logic          grp_en,
  output logic          flag,
  output logic [7:0]    rdata
);
  logic wr_clr;

  assign wr_clr = we && (addr == A_FLAG) && wdata[FLAG_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      grp_en <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (we && addr == A_MASK) mask   <= wdata[W-1:0];
      if (we && addr == A_CTRL) grp_en <= wdata[GRP_B];
      if (set_evt)                 flag <= 1'b1;
      else if (ack || wr_clr)      flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_MASK:  rdata[W-1:0]  = mask;
      A_CTRL:  rdata[GRP_B]  = grp_en;
      A_FLAG:  rdata[FLAG_B] = flag;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq
  import pinchg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic             gie,
  input  logic             vec_ack,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);
  logic [NPINS-1:0] pins_s;
  logic [NPINS-1:0] mask;
  logic             grp_en;
  logic             flag;
  logic             chg_evt;

  pinchg_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s)
  );

  pinchg_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .level(pins_s), .mask(mask),
    .grp_en(grp_en), .event_o(chg_evt)
  );

  pinchg_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata), .set_evt(chg_evt), .ack(vec_ack),
    .mask(mask), .grp_en(grp_en), .flag(flag), .rdata(reg_rdata)
  );

  assign irq = flag & grp_en & gie;
endmodule

// File: rtl/pinchg_irq_chk.sv
module pinchg_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic       vec_ack,
  input logic [1:0] reg_addr,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic       irq,
  input logic       flag,
  input logic       grp_en,
  input logic       chg_evt,
  input logic [7:0] mask
);
  logic wclr;
  assign wclr = reg_we && reg_addr == 2'd2 && reg_wdata[5];

  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0) |=> mask == $past(reg_wdata));

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && grp_en && flag));

  p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |=> flag);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_ack || wclr) && !chg_evt) |=> !flag);

  p_flag_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !chg_evt) |=> !flag);

  p_no_evt_grp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_en |-> !chg_evt);
endmodule

bind pinchg_irq pinchg_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .vec_ack(vec_ack),
  .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .irq(irq), .flag(flag), .grp_en(grp_en), .chg_evt(chg_evt), .mask(mask)
);

// File: tb/test_pinchg_irq.sv
`timescale 1ns/1ps
module test_pinchg_irq;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] pins = 0;
  logic       gie = 0;
  logic       vec_ack = 0;
  logic [1:0] reg_addr = 0;
  logic       reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Behavioural reference model
  logic [7:0] hist[$];
  logic [7:0] m_mask = 0;
  bit m_grp = 0, m_flag = 0;

  always #5 clk = ~clk;

  pinchg_irq i_pinchg_irq (
    .clk(clk), .rst_n(rst_n), .pins(pins), .gie(gie), .vec_ack(vec_ack),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return m_mask;
      2'd1: return m_grp ? 8'h20 : 8'h00;
      2'd2: return m_flag ? 8'h20 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {8'h00, 8'h00, 8'h00};
      m_mask = 0; m_grp = 0; m_flag = 0;
    end else begin
      // a change counts once it has been seen two edges late versus three edges late
      bit ev;
      ev = m_grp && (((hist[1] ^ hist[2]) & m_mask) != 0);
      if (ev) m_flag = 1;
      else if (vec_ack || (reg_we && reg_addr == 2 && reg_wdata[5])) m_flag = 0;
      if (reg_we && reg_addr == 0) m_mask = reg_wdata;
      if (reg_we && reg_addr == 1) m_grp = reg_wdata[5];
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check("R5 irq vs model", {7'b0, irq}, {7'b0, m_flag && m_grp && gie});
    check("R2 rdata vs model", reg_rdata, model_read(reg_addr));
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1; tick(); reg_we = 0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [7:0] exp);
    reg_addr = a; #1; check(tag, reg_rdata, exp);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick();
    rd("R1 mask reset", 0, 8'h00);
    rd("R1 ctrl reset", 1, 8'h00);
    rd("R1 flag reset", 2, 8'h00);
    check("R1 irq reset", {7'b0, irq}, 8'h00);

    wr(0, 8'h0F); rd("R2 mask readback", 0, 8'h0F);
    wr(1, 8'hFF); rd("R2 ctrl only bit5", 1, 8'h20);

    reg_addr = 2;
    pins[0] = 1; tick(); rd("R3 flag after 1 edge", 2, 8'h00);
    tick(); rd("R3 flag after 2 edges", 2, 8'h00);
    tick(); rd("R3 flag after 3 edges", 2, 8'h20);
    rd("R9 rising edge sets", 2, 8'h20);
    check("R5 irq low without gie", {7'b0, irq}, 8'h00);
    gie = 1; #1; check("R5 irq high", {7'b0, irq}, 8'h01);

    wr(2, 8'hDF); rd("R6 write zero keeps flag", 2, 8'h20);
    wr(2, 8'h20); rd("R6 write one clears", 2, 8'h00);
    check("R6 irq drops", {7'b0, irq}, 8'h00);

    pins[0] = 0; tick(4); rd("R9 falling edge sets", 2, 8'h20);
    vec_ack = 1; tick(); vec_ack = 0; rd("R6 ack clears", 2, 8'h00);

    pins[7] = 1; tick(5); rd("R4 masked pin ignored", 2, 8'h00);
    wr(0, 8'h8F); tick(4); rd("R8 unmask no event", 2, 8'h00);

    wr(1, 8'h00); pins[1] = 1; tick(5); rd("R4 group disabled ignored", 2, 8'h00);
    wr(1, 8'h20); tick(4); rd("R4 re-enable no stale event", 2, 8'h00);

    pins[2] = 1; tick(); tick(); vec_ack = 1; tick(); vec_ack = 0;
    rd("R7 set beats ack", 2, 8'h20);
    wr(2, 8'h20); rd("R6 cleared again", 2, 8'h00);
    pins[3] = 1; tick(); tick(); reg_addr = 2; reg_wdata = 8'h20; reg_we = 1;
    tick(); reg_we = 0; rd("R7 set beats write one", 2, 8'h20);

    pins = 8'h00; tick(6); rd("R9 multi-pin fall sets", 2, 8'h20);
    tick(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule